// File: doc/BRIEF.md
# Bounded GET payload sequencer

This block produces the byte stream that answers a host GET on a UART channel tunnelled over a serial host link. After a start strobe it sends one response-code byte, then a short header, then a payload read from a show-ahead transmit FIFO. The payload length is taken from the FIFO's used-word count at the moment the header begins, clamped to a maximum. Because that count crosses a clock boundary, it may be stale. The header carries the latched length, so the host learns exactly how many payload bytes follow.

The output side uses a valid/ready byte handshake, and every phase stalls cleanly when the consumer is not ready. A 12-bit down-counter paces the payload. A latched length of zero skips the payload phase and never loads the counter with length minus one. The FIFO is popped only when it reports data. If it runs dry while payload bytes are still owed, the show-ahead word is sent again with an underrun flag. The sequencer then raises done for one cycle and returns to idle.

Top module: `get_payload_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `byte_valid_o`, `fifo_pop_o`, `underrun_o` and `done_o` are all 0.
- R2: A start strobe accepted in idle makes `byte_valid_o` rise in the next cycle. The first byte is the response code (default 8'hA5), followed by exactly 3 header bytes, then the payload.
- R3: The length is latched on the clock edge that accepts the response-code byte, as min(`used_i`, 61). Header byte 0 is the tag 8'h5C, header byte 1 is length[15:8] (zero-extended), and header byte 2 is length[7:0].
- R4: Exactly the latched number of payload bytes is sent, each equal to the FIFO head at acceptance. A change of `used_i` after the latch has no effect on the count.
- R5: A latched length of 0 sends no payload byte: done follows the last header byte. The payload counter never holds a value above 60, so it never wraps.
- R6: `fifo_pop_o` is high only when a payload byte is accepted (`byte_valid_o` and `byte_ready_i`) while `fifo_empty_i` is 0. The number of pops equals min(FIFO contents, latched length).
- R7: A payload byte offered while `fifo_empty_i` is 1 carries the show-ahead word with `underrun_o` = 1 and no pop, and it still counts toward the length.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last byte is accepted, with `byte_valid_o` low. The block is then idle.
- R9: While `byte_ready_i` is 0, `byte_valid_o` stays high and no byte is lost or duplicated.
- R10: `start_i` outside idle is ignored: no second response is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | GET start strobe |
| used_i | input | USED_W (13) | FIFO used-word count as seen on the read side |
| fifo_empty_i | input | 1 | FIFO empty flag (registered) |
| fifo_data_i | input | 8 | Show-ahead FIFO head word |
| byte_ready_i | input | 1 | Consumer accepts the offered byte |
| byte_o | output | 8 | Offered byte |
| byte_valid_o | output | 1 | Byte offered |
| fifo_pop_o | output | 1 | FIFO read strobe |
| underrun_o | output | 1 | Offered payload byte is a repeated show-ahead word |
| done_o | output | 1 | One-cycle end-of-response pulse |

## Verification
The case hardest to reach from the ports is a latched length larger than the FIFO really holds. In that case the payload runs dry part-way through and must keep counting with repeated words. A related case is a count that changes right after the latch. The bench drives `used_i` independently of its own FIFO model, so it can claim more words than it loads, claim none, or alter the count as soon as the first header bytes pass. Stall patterns on `byte_ready_i` are laid over these runs to check that no byte is lost or duplicated.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CODE,
    PH_HDR,
    PH_PAY,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/gps_len_latch.sv
module gps_len_latch #(
  parameter int USED_W      = 13,
  parameter int CNT_W       = 12,
  parameter int MAX_PAYLOAD = 61
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [USED_W-1:0] used_i,
  output logic [CNT_W-1:0]  len_o,
  output logic              len_zero_o
);
  localparam logic [USED_W-1:0] CAP = USED_W'(MAX_PAYLOAD);

  logic [USED_W-1:0] clamped;
  logic [CNT_W-1:0]  len_q;

  assign clamped = (used_i > CAP) ? CAP : used_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        len_q <= '0;
    else if (capture_i) len_q <= CNT_W'(clamped);
  end

  assign len_o      = len_q;
  assign len_zero_o = (len_q == '0);
endmodule

// File: rtl/gps_pay_counter.sv
module gps_pay_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      // zero length must never become all-ones
      cnt_q <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
    end else if (step_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/gps_byte_mux.sv
module gps_byte_mux
  import gps_pkg::*;
#(
  parameter int          CNT_W     = 12,
  parameter int          HDR_BYTES = 3,
  parameter int          IDX_W     = 2,
  parameter logic [7:0]  RESP_CODE = 8'hA5,
  parameter logic [7:0]  HDR_TAG   = 8'h5C
) (
  input  phase_e           phase_i,
  input  logic [IDX_W-1:0] hdr_idx_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [7:0]       fifo_data_i,
  output logic [7:0]       byte_o
);
  localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(HDR_BYTES - 2);
  localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(HDR_BYTES - 1);

  logic [15:0] len_ext;
  assign len_ext = 16'(len_i);

  always_comb begin
    byte_o = 8'h00;
    unique case (phase_i)
      PH_CODE: byte_o = RESP_CODE;
      PH_HDR: begin
        if (hdr_idx_i == '0)          byte_o = HDR_TAG;
        else if (hdr_idx_i == IDX_HI) byte_o = len_ext[15:8];
        else if (hdr_idx_i == IDX_LO) byte_o = len_ext[7:0];
        else                          byte_o = 8'h00;
      end
      PH_PAY:  byte_o = fifo_data_i;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/gps_fsm.sv
module gps_fsm
  import gps_pkg::*;
#(
  parameter int HDR_BYTES = 3,
  parameter int IDX_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic             empty_i,
  input  logic             len_zero_i,
  input  logic             last_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] hdr_idx_o,
  output logic             valid_o,
  output logic             capture_o,
  output logic             load_o,
  output logic             step_o,
  output logic             pop_o,
  output logic             underrun_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept;

  assign valid_o = (phase_q == PH_CODE) || (phase_q == PH_HDR) || (phase_q == PH_PAY);
  assign accept  = valid_o && ready_i;

  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    capture_o = 1'b0;
    load_o    = 1'b0;
    step_o    = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = PH_CODE;
      PH_CODE: if (accept) begin
        phase_d   = PH_HDR;
        idx_d     = '0;
        capture_o = 1'b1;
      end
      PH_HDR: if (accept) begin
        if (idx_q == IDX_LAST) begin
          if (len_zero_i) phase_d = PH_DONE;
          else begin
            phase_d = PH_PAY;
            load_o  = 1'b1;
          end
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      PH_PAY: if (accept) begin
        if (last_i) phase_d = PH_DONE;
        else        step_o  = 1'b1;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase_o    = phase_q;
  assign hdr_idx_o  = idx_q;
  assign pop_o      = (phase_q == PH_PAY) && accept && !empty_i;
  assign underrun_o = (phase_q == PH_PAY) && empty_i;
  assign done_o     = (phase_q == PH_DONE);
endmodule

// File: rtl/get_payload_seq.sv
module get_payload_seq
  import gps_pkg::*;
#(
  parameter int         USED_W      = 13,
  parameter int         CNT_W       = 12,
  parameter int         MAX_PAYLOAD = 61,
  parameter int         HDR_BYTES   = 3,
  parameter logic [7:0] RESP_CODE   = 8'hA5,
  parameter logic [7:0] HDR_TAG     = 8'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [USED_W-1:0] used_i,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_data_i,
  input  logic              byte_ready_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  output logic              fifo_pop_o,
  output logic              underrun_o,
  output logic              done_o
);
  localparam int IDX_W = (HDR_BYTES > 2) ? $clog2(HDR_BYTES) : 1;

  phase_e           phase;
  logic [IDX_W-1:0] hdr_idx;
  logic             capture, load, step, last, len_zero;
  logic [CNT_W-1:0] len, pay_cnt;

  gps_fsm #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .start_i,
    .ready_i(byte_ready_i), .empty_i(fifo_empty_i),
    .len_zero_i(len_zero), .last_i(last),
    .phase_o(phase), .hdr_idx_o(hdr_idx), .valid_o(byte_valid_o),
    .capture_o(capture), .load_o(load), .step_o(step),
    .pop_o(fifo_pop_o), .underrun_o(underrun_o), .done_o(done_o)
  );

  gps_len_latch #(.USED_W(USED_W), .CNT_W(CNT_W), .MAX_PAYLOAD(MAX_PAYLOAD)) u_len (
    .clk_i, .rst_ni, .capture_i(capture), .used_i,
    .len_o(len), .len_zero_o(len_zero)
  );

  gps_pay_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .step_i(step),
    .cnt_o(pay_cnt), .last_o(last)
  );

  gps_byte_mux #(
    .CNT_W(CNT_W), .HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W),
    .RESP_CODE(RESP_CODE), .HDR_TAG(HDR_TAG)
  ) u_mux (
    .phase_i(phase), .hdr_idx_i(hdr_idx), .len_i(len),
    .fifo_data_i, .byte_o
  );
endmodule

// File: rtl/gps_checker.sv
module gps_checker
  import gps_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int MAX_PAYLOAD = 61
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             fifo_empty_i,
  input logic             byte_ready_i,
  input logic             byte_valid_o,
  input logic             fifo_pop_o,
  input logic             underrun_o,
  input logic             done_o,
  input phase_e           phase_i,
  input logic [CNT_W-1:0] pay_cnt_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PAYLOAD - 1);

  p_start_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_IDLE && start_i) |=> (phase_i == PH_CODE && byte_valid_o));

  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_cnt_i <= CNT_MAX);

  p_pop_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> (!fifo_empty_i && byte_valid_o && byte_ready_i));

  p_underrun_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (byte_valid_o && fifo_empty_i && !fifo_pop_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !byte_valid_o));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_valid_o);

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=> byte_valid_o);

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_HDR || phase_i == PH_PAY) |=> phase_i != PH_CODE);
endmodule

bind get_payload_seq gps_checker #(.CNT_W(CNT_W), .MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .fifo_empty_i(fifo_empty_i), .byte_ready_i(byte_ready_i),
  .byte_valid_o(byte_valid_o), .fifo_pop_o(fifo_pop_o),
  .underrun_o(underrun_o), .done_o(done_o),
  .phase_i(phase), .pay_cnt_i(pay_cnt)
);

// File: tb/tb_get_payload_seq.sv
module tb_get_payload_seq;
  localparam int MAXP = 61;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [12:0] used_i = '0;
  logic        fifo_empty_i = 1'b1;
  logic [7:0]  fifo_data_i = 8'h00;
  logic        byte_ready_i = 1'b1;
  logic [7:0]  byte_o;
  logic        byte_valid_o, fifo_pop_o, underrun_o, done_o;

  always #5 clk = ~clk;

  get_payload_seq dut (
    .clk_i(clk), .rst_ni, .start_i, .used_i, .fifo_empty_i, .fifo_data_i,
    .byte_ready_i, .byte_o, .byte_valid_o, .fifo_pop_o, .underrun_o, .done_o
  );

  logic [7:0] fq[$];
  logic [7:0] last_pop = 8'h00;
  logic [7:0] got[$];
  logic       got_ur[$];
  int pops, done_cnt, done_cyc, last_acc, cyc, rcnt, ready_mode;
  bit pop_pend;
  int nchk, nerr;

  function automatic void refresh();
    fifo_empty_i = (fq.size() == 0);
    fifo_data_i  = (fq.size() == 0) ? last_pop : fq[0];
  endfunction

  // FIFO model and ready pattern update just after the edge
  always @(posedge clk) begin
    #1;
    if (pop_pend) begin
      last_pop = fq.pop_front();
      pop_pend = 1'b0;
    end
    refresh();
    rcnt++;
    byte_ready_i = (ready_mode == 0) ? 1'b1 :
                   (ready_mode == 1) ? rcnt[0] : (rcnt % 3 == 0);
  end

  // monitor mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (byte_valid_o && byte_ready_i) begin
      got.push_back(byte_o);
      got_ur.push_back(underrun_o);
      last_acc = cyc;
    end
    if (fifo_pop_o) begin
      pops++;
      pop_pend = 1'b1;
    end
    if (done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!byte_valid_o && !fifo_pop_o && !underrun_o && !done_o, "R1", "outputs in reset",
        {byte_valid_o, fifo_pop_o, underrun_o, done_o}, 0);
    @(posedge clk); #2 rst_ni = 1'b1;
    @(negedge clk);
    chk(!byte_valid_o && !fifo_pop_o && !underrun_o && !done_o, "R1", "outputs after reset",
        {byte_valid_o, fifo_pop_o, underrun_o, done_o}, 0);
  endtask

  task automatic run_get(string req, int used, int nfifo, int mode, bit chg, bit rs, int seed);
    logic [7:0] e[$];
    bit         eur[$];
    logic [7:0] stale;
    int len, t;
    bit rs_done;
    @(posedge clk); #2;
    fq.delete();
    for (int i = 0; i < nfifo; i++) fq.push_back(8'(seed + 3 * i));
    refresh();
    stale = last_pop;
    ready_mode = mode;
    used_i = 13'(used);
    got.delete(); got_ur.delete();
    pops = 0; done_cnt = 0; done_cyc = 0; last_acc = 0;
    start_i = 1'b1;
    @(posedge clk); #2 start_i = 1'b0;
    chk(byte_valid_o, "R2", "valid after start", byte_valid_o, 1);
    t = 0; rs_done = 0;
    while (done_cnt == 0 && t < 3000) begin
      @(posedge clk); #2;
      t++;
      if (chg && got.size() >= 2) used_i = 13'd40;
      start_i = rs && !rs_done && got.size() >= 6;
      if (start_i) rs_done = 1;
    end
    start_i = 1'b0;
    chk(done_cnt != 0, "R8", "done seen", done_cnt, 1);
    repeat (4) @(posedge clk);
    #2;
    len = (used > MAXP) ? MAXP : used;
    e = '{8'hA5, 8'h5C, 8'(len >> 8), 8'(len & 255)};
    eur = '{0, 0, 0, 0};
    for (int k = 0; k < len; k++) begin
      if (k < nfifo) begin
        e.push_back(8'(seed + 3 * k)); eur.push_back(0);
      end else begin
        e.push_back((nfifo > 0) ? 8'(seed + 3 * (nfifo - 1)) : stale); eur.push_back(1);
      end
    end
    chk(got.size() == e.size(), req, "stream length", got.size(), e.size());
    for (int k = 0; k < e.size() && k < got.size(); k++) begin
      chk(got[k] == e[k], (k == 0) ? "R2" : (k < 4) ? "R3" : "R4",
          $sformatf("byte %0d", k), got[k], e[k]);
      chk(got_ur[k] == eur[k], "R7", $sformatf("underrun flag %0d", k), got_ur[k], eur[k]);
    end
    chk(pops == ((nfifo < len) ? nfifo : len), "R6", "pop count", pops,
        (nfifo < len) ? nfifo : len);
    chk(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
    chk(done_cyc == last_acc + 1, "R8", "done after last byte", done_cyc, last_acc + 1);
    chk(!byte_valid_o && !done_o, "R8", "idle after done", {byte_valid_o, done_o}, 0);
    ready_mode = 0;
  endtask

  task automatic t_basic();     run_get("R4", 5, 5, 0, 0, 0, 16);   endtask
  task automatic t_cap();       run_get("R3", 100, 70, 0, 0, 0, 1); endtask
  task automatic t_zero();      run_get("R5", 0, 4, 0, 0, 0, 50);   endtask
  task automatic t_underrun();  run_get("R7", 8, 3, 0, 0, 0, 200);  endtask
  task automatic t_empty_all(); run_get("R7", 2, 0, 0, 0, 0, 9);    endtask
  task automatic t_stale_cnt(); run_get("R4", 5, 20, 0, 1, 0, 77);  endtask
  task automatic t_stall();     run_get("R9", 6, 6, 1, 0, 0, 120);  endtask
  task automatic t_stall3();    run_get("R9", 9, 4, 2, 0, 0, 33);   endtask
  task automatic t_restart();   run_get("R10", 7, 7, 0, 0, 1, 90);  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0; ready_mode = 0;
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_cap();
    t_zero();
    t_underrun();
    t_empty_all();
    t_stale_cnt();
    t_stall();
    t_stall3();
    t_restart();
    summary();
    $finish;
  end
endmodule